// File: doc/BRIEF.md
# Key-protected watchdog timer

A memory-mapped watchdog that counts down once per tick-enable pulse from a programmable 15-bit timeout. When the count runs out, it raises a one-cycle reset request. It also latches an expiry status and reloads itself so that it keeps watching. The tick is expected to come from an external 10 ms time base. The reset itself belongs to the surrounding system.

Software changes the block's state only by writing exact 16-bit key words, zero-extended to 32 bits, to dedicated registers. This covers feeding, re-enabling, clearing the status and the two-step disable. The enable state and the status read back as distinctive codes. The count read carries a flag that marks a value that is changing in this very cycle.

A warning event is set one tick before expiry and drives a maskable interrupt. A debug-mode input halts counting unless an override bit is set.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the timer is disabled and the disable-2 register (offset 0x0C) reads 0x0000DABE. Status (0x10) reads 0, the count (0x14) reads 0, the timeout (0x04) reads the default of 100, and both `wd_irq` and `wd_rst_req` are low.
- R2: The timeout register at 0x04 keeps write-data bits 14:0 and reads them back. Higher data bits are ignored and read as 0.
- R3: Writing exactly 0x0000FEED to the feed register (0x00) loads the count from the timeout register in the next cycle. Any other value leaves the count unchanged.
- R4: While the timer is enabled and not halted, each cycle with `tick_en` high lowers the count by one. While the timer is disabled, the count holds.
- R5: Writing 0x00002BAD to 0x08 arms a disable. A following write of 0x0000CAFE to 0x0C then disables the timer, and 0x0C reads 0xDABE. Every write to 0x0C clears the arm, so a repeated 0xCAFE is harmless. A 0xCAFE with no arm, or one that follows a wrong key written to 0x0C, leaves the timer enabled.
- R6: Writing 0x0000ACED to the restart register (0x1C) enables the timer, and 0x0C then reads 0. Counting resumes from the held count.
- R7: A tick taken while the count is 1 or 0 expires the timer. `wd_rst_req` is high for the following cycle, the status reads 0x0000CFE8, and the count is reloaded from the timeout register and keeps counting.
- R8: Writing 0x0000E8B4 to the status register clears it to 0. Any other value leaves it unchanged. An expiry in the same cycle wins over the clear.
- R9: A tick that moves the count from 2 to 1 sets event bit 0 (offset 0x20). `wd_irq` is the event ANDed with mask bit 0 (offset 0x24). Writing a word with bit 0 set to 0x20 clears the event. Writing bit 0 set to the force register (0x28) sets the event. A set in the same cycle wins over a clear.
- R10: The count read returns the count in bits 14:0. Bit 15 is high exactly while `tick_en` is high and the timer is enabled and not halted.
- R11: The debug register (0x18) reads `dbg_mode` in bit 1 and the stored override in bit 0. While `dbg_mode` is high and the override is 0, the count holds.
- R12: The write-only key registers (0x00, 0x08, 0x1C) and the force register (0x28) read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_en | input | 1 | Count-down tick, one cycle per period |
| dbg_mode | input | 1 | Debug mode active |
| wd_irq | output | 1 | Early-warning interrupt |
| wd_rst_req | output | 1 | System reset request, one cycle |

## Verification
The assertions assume that every register write is a single-cycle strobe and that the count can move only on a cycle with no bus write. That is why the reload, halt and warning properties exclude cycles that follow a write. They also assume that `dbg_mode` and `tick_en` are synchronous to `clk`. The stimulus drives every input on the falling edge, holds `bus_we` for exactly one cycle, and never raises `tick_en` in the same cycle as a write. This keeps each count change tied to a single cause.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

  localparam logic [7:0] OFS_FEED    = 8'h00;
  localparam logic [7:0] OFS_TIMEOUT = 8'h04;
  localparam logic [7:0] OFS_DIS1    = 8'h08;
  localparam logic [7:0] OFS_DIS2    = 8'h0C;
  localparam logic [7:0] OFS_STATUS  = 8'h10;
  localparam logic [7:0] OFS_COUNT   = 8'h14;
  localparam logic [7:0] OFS_DEBUG   = 8'h18;
  localparam logic [7:0] OFS_RESTART = 8'h1C;
  localparam logic [7:0] OFS_EVENT   = 8'h20;
  localparam logic [7:0] OFS_MASK    = 8'h24;
  localparam logic [7:0] OFS_FORCE   = 8'h28;

  localparam logic [15:0] KEY_FEED    = 16'hFEED;
  localparam logic [15:0] KEY_ARM     = 16'h2BAD;
  localparam logic [15:0] KEY_DISABLE = 16'hCAFE;
  localparam logic [15:0] KEY_RESUME  = 16'hACED;
  localparam logic [15:0] KEY_CLEAR   = 16'hE8B4;

  localparam logic [15:0] CODE_OFF     = 16'hDABE;
  localparam logic [15:0] CODE_EXPIRED = 16'hCFE8;

  typedef struct packed {
    logic feed;
    logic resume;
    logic arm;
    logic dis_wr;
    logic dis_key;
    logic st_clr;
    logic to_wr;
    logic mask_wr;
    logic ovr_wr;
    logic ev_ack;
    logic ev_force;
  } kwd_strobe_t;

endpackage

// File: rtl/kwd_decode.sv
module kwd_decode
  import kwd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output kwd_strobe_t       stb
);

  localparam int KEY_W = 16;

  logic key_word;
  logic [KEY_W-1:0] key_val;

  assign key_val  = wdata[KEY_W-1:0];
  assign key_word = (wdata[DATA_W-1:KEY_W] == '0);

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_comb begin
    stb          = '0;
    stb.feed     = we && hit(addr, OFS_FEED)    && key_word && (key_val == KEY_FEED);
    stb.resume   = we && hit(addr, OFS_RESTART) && key_word && (key_val == KEY_RESUME);
    stb.arm      = we && hit(addr, OFS_DIS1)    && key_word && (key_val == KEY_ARM);
    stb.dis_wr   = we && hit(addr, OFS_DIS2);
    stb.dis_key  = key_word && (key_val == KEY_DISABLE);
    stb.st_clr   = we && hit(addr, OFS_STATUS)  && key_word && (key_val == KEY_CLEAR);
    stb.to_wr    = we && hit(addr, OFS_TIMEOUT);
    stb.mask_wr  = we && hit(addr, OFS_MASK);
    stb.ovr_wr   = we && hit(addr, OFS_DEBUG);
    stb.ev_ack   = we && hit(addr, OFS_EVENT)   && wdata[0];
    stb.ev_force = we && hit(addr, OFS_FORCE)   && wdata[0];
  end

endmodule

// File: rtl/kwd_ctrl.sv
module kwd_ctrl
  import kwd_pkg::*;
#(
  parameter int          TW          = 15,
  parameter logic [TW-1:0] DEF_TIMEOUT = TW'(100)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  kwd_strobe_t   stb,
  input  logic [TW-1:0] wdata_lo,
  input  logic          wbit0,
  input  logic          expire,
  input  logic          dbg_mode,
  output logic          enabled,
  output logic          status,
  output logic [TW-1:0] timeout,
  output logic          mask,
  output logic          ovr,
  output logic          run_ok
);

  logic en_q, en_d;
  logic arm_q, arm_d;
  logic st_q, st_d;
  logic [TW-1:0] to_q;
  logic mask_q, ovr_q;

  always_comb begin
    en_d = en_q;
    if (stb.resume)
      en_d = 1'b1;
    else if (stb.dis_wr && stb.dis_key && arm_q)
      en_d = 1'b0;

    arm_d = arm_q;
    if (stb.arm)
      arm_d = 1'b1;
    else if (stb.dis_wr)
      arm_d = 1'b0;

    st_d = st_q;
    if (expire)
      st_d = 1'b1;
    else if (stb.st_clr)
      st_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      arm_q <= 1'b0;
      st_q  <= 1'b0;
    end else begin
      en_q  <= en_d;
      arm_q <= arm_d;
      st_q  <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      to_q <= DEF_TIMEOUT;
    else if (stb.to_wr)
      to_q <= wdata_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask_q <= 1'b0;
    else if (stb.mask_wr)
      mask_q <= wbit0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ovr_q <= 1'b0;
    else if (stb.ovr_wr)
      ovr_q <= wbit0;
  end

  assign enabled = en_q;
  assign status  = st_q;
  assign timeout = to_q;
  assign mask    = mask_q;
  assign ovr     = ovr_q;
  assign run_ok  = en_q & (~dbg_mode | ovr_q);

endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int TW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          run_ok,
  input  logic          feed,
  input  logic [TW-1:0] reload,
  output logic [TW-1:0] count,
  output logic          unstable,
  output logic          warn,
  output logic          expire,
  output logic          rst_req
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          req_q;
  logic          adv;

  assign adv = tick_en & run_ok;

  always_comb begin
    cnt_d  = cnt_q;
    warn   = 1'b0;
    expire = 1'b0;
    if (feed) begin
      cnt_d = reload;
    end else if (adv) begin
      if (cnt_q <= TW'(1)) begin
        expire = 1'b1;
        cnt_d  = reload;
      end else begin
        cnt_d = cnt_q - TW'(1);
        warn  = (cnt_q == TW'(2));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= expire;
    end
  end

  assign count    = cnt_q;
  assign unstable = adv;
  assign rst_req  = req_q;

endmodule

// File: rtl/kwd_warn.sv
module kwd_warn (
  input  logic clk,
  input  logic rst_n,
  input  logic warn,
  input  logic force_set,
  input  logic ack,
  input  logic mask,
  output logic event_o,
  output logic irq
);

  logic ev_q, ev_d;

  always_comb begin
    ev_d = ev_q;
    if (warn || force_set)
      ev_d = 1'b1;
    else if (ack)
      ev_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ev_q <= 1'b0;
    else
      ev_q <= ev_d;
  end

  assign event_o = ev_q;
  assign irq     = ev_q & mask;

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import kwd_pkg::*;
#(
  parameter int            ADDR_W      = 8,
  parameter int            DATA_W      = 32,
  parameter int            TW          = 15,
  parameter logic [TW-1:0] DEF_TIMEOUT = TW'(100)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_en,
  input  logic              dbg_mode,
  output logic              wd_irq,
  output logic              wd_rst_req
);

  localparam int CODE_W = 16;

  kwd_strobe_t   stb;
  logic          en_w, stat_w, mask_w, ovr_w, run_ok_w;
  logic [TW-1:0] to_w, cnt_w;
  logic          unstable_w, warn_w, expire_w, ev_w;

  kwd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .addr  (bus_addr),
    .we    (bus_we),
    .wdata (bus_wdata),
    .stb   (stb)
  );

  kwd_ctrl #(.TW(TW), .DEF_TIMEOUT(DEF_TIMEOUT)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .wdata_lo (bus_wdata[TW-1:0]),
    .wbit0    (bus_wdata[0]),
    .expire   (expire_w),
    .dbg_mode (dbg_mode),
    .enabled  (en_w),
    .status   (stat_w),
    .timeout  (to_w),
    .mask     (mask_w),
    .ovr      (ovr_w),
    .run_ok   (run_ok_w)
  );

  kwd_counter #(.TW(TW)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .run_ok   (run_ok_w),
    .feed     (stb.feed),
    .reload   (to_w),
    .count    (cnt_w),
    .unstable (unstable_w),
    .warn     (warn_w),
    .expire   (expire_w),
    .rst_req  (wd_rst_req)
  );

  kwd_warn u_warn (
    .clk       (clk),
    .rst_n     (rst_n),
    .warn      (warn_w),
    .force_set (stb.ev_force),
    .ack       (stb.ev_ack),
    .mask      (mask_w),
    .event_o   (ev_w),
    .irq       (wd_irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_TIMEOUT): bus_rdata[TW-1:0] = to_w;
      ADDR_W'(OFS_DIS2):    bus_rdata[CODE_W-1:0] = en_w ? '0 : CODE_OFF;
      ADDR_W'(OFS_STATUS):  bus_rdata[CODE_W-1:0] = stat_w ? CODE_EXPIRED : '0;
      ADDR_W'(OFS_COUNT):   bus_rdata[TW:0] = {unstable_w, cnt_w};
      ADDR_W'(OFS_DEBUG):   bus_rdata[1:0] = {dbg_mode, ovr_w};
      ADDR_W'(OFS_EVENT):   bus_rdata[0] = ev_w;
      ADDR_W'(OFS_MASK):    bus_rdata[0] = mask_w;
      default:              bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/kwd_chk.sv
module kwd_chk #(
  parameter int TW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic          dbg_mode,
  input logic          rst_req,
  input logic          en,
  input logic          ovr,
  input logic          stat,
  input logic          ev,
  input logic [TW-1:0] cnt,
  input logic [TW-1:0] to
);

  // R7
  expire_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> stat);

  // R7
  expire_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && !$past(bus_we)) |-> (cnt == to));

  // R4
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !bus_we) |=> $stable(cnt));

  // R11
  debug_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode && !ovr && !bus_we) |=> $stable(cnt));

  // R9
  warn_one_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ev) && !$past(bus_we)) |-> (cnt == TW'(1)));

endmodule

bind keyed_wdog kwd_chk #(.TW(TW)) u_kwd_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_we   (bus_we),
  .dbg_mode (dbg_mode),
  .rst_req  (wd_rst_req),
  .en       (en_w),
  .ovr      (ovr_w),
  .stat     (stat_w),
  .ev       (ev_w),
  .cnt      (cnt_w),
  .to       (to_w)
);

// File: tb/keyed_wdog_bench.sv
`timescale 1ns/1ps
module keyed_wdog_bench;

  localparam logic [7:0] A_FEED = 8'h00, A_TO = 8'h04, A_D1 = 8'h08, A_D2 = 8'h0C;
  localparam logic [7:0] A_ST = 8'h10, A_CNT = 8'h14, A_DBG = 8'h18, A_RR = 8'h1C;
  localparam logic [7:0] A_EV = 8'h20, A_MSK = 8'h24, A_FRC = 8'h28;

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        tick_en;
  logic        dbg_mode;
  logic        wd_irq;
  logic        wd_rst_req;

  int checks;
  int errors;
  logic done;

  keyed_wdog u_keyed_wdog (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .tick_en    (tick_en),
    .dbg_mode   (dbg_mode),
    .wd_irq     (wd_irq),
    .wd_rst_req (wd_rst_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_we    = 1'b1;
    bus_wdata = d;
    @(negedge clk);
    bus_we    = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic tick_once;
    @(negedge clk);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_D2, v);  chk("R1 disable-2 code", v, 32'h0000DABE);
    rd(A_ST, v);  chk("R1 status", v, 32'h0);
    rd(A_CNT, v); chk("R1 count", v, 32'h0);
    rd(A_TO, v);  chk("R1 timeout default", v, 32'd100);
    chk("R1 irq/rst_req", {30'h0, wd_irq, wd_rst_req}, 32'h0);
  endtask

  task automatic t_timeout_reg;
    logic [31:0] v;
    wr(A_TO, 32'hFFFF_1234); rd(A_TO, v); chk("R2 upper bits dropped", v, 32'h1234);
    wr(A_TO, 32'h0000_8005); rd(A_TO, v); chk("R2 bit15 dropped", v, 32'h5);
  endtask

  task automatic t_feed;
    logic [31:0] v;
    wr(A_FEED, 32'h1234);     rd(A_CNT, v); chk("R3 wrong key ignored", v, 32'h0);
    wr(A_FEED, 32'h0001FEED); rd(A_CNT, v); chk("R3 inexact key ignored", v, 32'h0);
    wr(A_FEED, 32'hFEED);     rd(A_CNT, v); chk("R3 feed reloads", v, 32'h5);
  endtask

  task automatic t_disabled_hold;
    logic [31:0] v;
    repeat (3) tick_once;
    rd(A_CNT, v); chk("R4 disabled holds count", v, 32'h5);
    rd(A_D2, v);  chk("R4 still disabled", v, 32'h0000DABE);
  endtask

  task automatic t_restart;
    logic [31:0] v;
    wr(A_RR, 32'h1234); rd(A_D2, v); chk("R6 wrong resume key", v, 32'h0000DABE);
    wr(A_RR, 32'hACED); rd(A_D2, v); chk("R6 resume enables", v, 32'h0);
    tick_once;
    rd(A_CNT, v); chk("R4 tick decrements", v, 32'h4);
  endtask

  task automatic t_unstable;
    logic [31:0] v;
    @(negedge clk);
    tick_en = 1'b1;
    rd(A_CNT, v); chk("R10 flag during tick", v, 32'h8004);
    @(negedge clk);
    tick_en = 1'b0;
    rd(A_CNT, v); chk("R10 stable after tick", v, 32'h0003);
  endtask

  task automatic t_warning;
    logic [31:0] v;
    tick_once;
    rd(A_EV, v); chk("R9 no event at 2", v, 32'h0);
    tick_once;
    rd(A_CNT, v); chk("R9 count at 1", v, 32'h1);
    rd(A_EV, v);  chk("R9 event set", v, 32'h1);
    chk("R9 irq masked", {31'h0, wd_irq}, 32'h0);
    wr(A_MSK, 32'h1);
    chk("R9 irq unmasked", {31'h0, wd_irq}, 32'h1);
    wr(A_EV, 32'h0); rd(A_EV, v); chk("R9 zero write keeps event", v, 32'h1);
    wr(A_EV, 32'h1); rd(A_EV, v); chk("R9 ack clears event", v, 32'h0);
    chk("R9 irq dropped", {31'h0, wd_irq}, 32'h0);
  endtask

  task automatic t_expire;
    logic [31:0] v;
    chk("R7 no request before", {31'h0, wd_rst_req}, 32'h0);
    tick_once;
    chk("R7 reset request", {31'h0, wd_rst_req}, 32'h1);
    rd(A_ST, v);  chk("R7 status expired", v, 32'h0000CFE8);
    rd(A_CNT, v); chk("R7 count reloaded", v, 32'h5);
    @(negedge clk);
    chk("R7 request one cycle", {31'h0, wd_rst_req}, 32'h0);
    tick_once;
    rd(A_CNT, v); chk("R7 keeps running", v, 32'h4);
  endtask

  task automatic t_status_clear;
    logic [31:0] v;
    wr(A_ST, 32'h1234); rd(A_ST, v); chk("R8 wrong key keeps status", v, 32'h0000CFE8);
    wr(A_ST, 32'hE8B4); rd(A_ST, v); chk("R8 status cleared", v, 32'h0);
  endtask

  task automatic t_debug;
    logic [31:0] v;
    @(negedge clk); dbg_mode = 1'b1;
    rd(A_DBG, v); chk("R11 debug indication", v, 32'h2);
    tick_once;
    rd(A_CNT, v); chk("R11 halted in debug", v, 32'h4);
    wr(A_DBG, 32'h1);
    rd(A_DBG, v); chk("R11 override readback", v, 32'h3);
    tick_once;
    rd(A_CNT, v); chk("R11 override keeps running", v, 32'h3);
    wr(A_DBG, 32'h0);
    @(negedge clk); dbg_mode = 1'b0;
  endtask

  task automatic t_force;
    logic [31:0] v;
    wr(A_FRC, 32'h1);
    rd(A_EV, v); chk("R9 force sets event", v, 32'h1);
    chk("R9 forced irq", {31'h0, wd_irq}, 32'h1);
    wr(A_EV, 32'h1);
    wr(A_MSK, 32'h0);
    rd(A_EV, v); chk("R9 forced event acked", v, 32'h0);
    rd(A_CNT, v); chk("R9 force leaves count", v, 32'h3);
  endtask

  task automatic t_disable;
    logic [31:0] v;
    wr(A_D2, 32'hCAFE);
    rd(A_D2, v); chk("R5 unarmed disable ignored", v, 32'h0);
    wr(A_D1, 32'h2BAD);
    wr(A_D2, 32'h1111);
    wr(A_D2, 32'hCAFE);
    rd(A_D2, v); chk("R5 wrong key cancels arm", v, 32'h0);
    tick_once;
    rd(A_CNT, v); chk("R5 still counting", v, 32'h2);
    wr(A_D1, 32'h2BAD);
    wr(A_D2, 32'hCAFE);
    rd(A_D2, v); chk("R5 disabled", v, 32'h0000DABE);
    wr(A_D2, 32'hCAFE);
    rd(A_D2, v); chk("R5 repeated key harmless", v, 32'h0000DABE);
    tick_once;
    rd(A_CNT, v); chk("R5 disabled holds", v, 32'h2);
  endtask

  task automatic t_keyregs;
    logic [31:0] v;
    rd(A_FEED, v); chk("R12 feed reads 0", v, 32'h0);
    rd(A_D1, v);   chk("R12 disable-1 reads 0", v, 32'h0);
    rd(A_RR, v);   chk("R12 restart reads 0", v, 32'h0);
    rd(A_FRC, v);  chk("R12 force reads 0", v, 32'h0);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    tick_en = 1'b0; dbg_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_timeout_reg;
    t_feed;
    t_disabled_hold;
    t_restart;
    t_unstable;
    t_warning;
    t_expire;
    t_status_clear;
    t_debug;
    t_force;
    t_disable;
    t_keyregs;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule